// File: doc/BRIEF.md
# Handshake-Qualified Trace Recorder

This block is an embedded logic analyzer. It watches a wide vector of probed design signals plus a set of valid/ready channel pairs, and writes one frame into an on-chip buffer on every clock edge where at least one channel completes a handshake. Valid and ready must both be high on the same channel for that channel to count. Each frame holds the probe vector, the per-channel handshake flags and a 32-bit cycle timestamp. Recording runs only while the block is armed. The host arms the block with a start command that carries a delay, and disarms it with a stop command that also carries a delay.

The host reaches the block through a command word and a data word, both 64 bits wide. Writing a command picks what the data word shows: the frame width, the buffer depth, the number of frames captured, or the stored frames themselves. In that last case each read pulse advances through the frames in 64-bit pieces. Command word layout: opcode in bits [3:0], delay argument in bits [DLY_W+3:4]. Opcodes: 0 = frame width, 1 = readout, 2 = start, 3 = buffer depth, 4 = stop, 5 = frame count.

Top module: `trace_scope`

## Requirements
- R1: After reset the buffer is empty, the block is not armed, the frame count reads 0 and `data_o` is 0.
- R2: Opcode 0 makes `data_o` show the frame width in bits, which is 32 + CHAN + PROBE_W (76 with the defaults).
- R3: Opcode 3 makes `data_o` show the number of frames the buffer holds (DEPTH).
- R4: Opcode 5 makes `data_o` show the number of frames stored so far.
- R5: A frame is written only on an armed edge where some channel has valid and ready high together. Valid without ready on the same channel, or a handshake while the block is disarmed, writes nothing.
- R6: A start command with delay D, written at edge 0, arms the block at edge D. Handshakes at edges 1..D are dropped and handshakes from edge D+1 onward are recorded. D = 0 therefore records from the very next edge.
- R7: A stop command with delay D, written at edge 0, still records handshakes at edges 0..D and drops those from edge D+1 onward.
- R8: Frame layout: timestamp in bits [31:0], the handshake flag of channel c (valid AND ready) in bit 32+c, and the probe vector above those. The frame is zero-padded to a whole number of 64-bit words, and the words are read out least significant first, frame after frame.
- R9: The timestamp is a 32-bit counter that reset clears and that advances by one on every edge. A frame stores the value the counter holds at its capture edge.
- R10: When DEPTH frames are stored the buffer stops accepting frames. It does not wrap, it keeps the first DEPTH frames, and the count stays at DEPTH.
- R11: In readout mode, once the last word of the last stored frame has been read, `data_o` shows 0 and further read pulses change nothing.
- R12: A start command discards any stored frames: the count returns to 0 and readout restarts at frame 0.
- R13: Writing opcode 1 restarts readout at word 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_i | input | PROBE_W | Probed signal vector |
| chan_valid_i | input | CHAN | Valid line of each monitored channel |
| chan_ready_i | input | CHAN | Ready line of each monitored channel |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 64 | Command word: opcode [3:0], delay [DLY_W+3:4] |
| data_rd_i | input | 1 | Read pulse; in readout mode it advances to the next word |
| data_o | output | 64 | Value selected by the last query or readout command |

## Verification
The bench places handshakes exactly on the boundary edges of the start and stop delays. A design off by one cycle in either delay would gain or lose the first or last frame, and that shows up as a count mismatch or as a shifted timestamp in the readout stream. It presents valid without ready, and handshakes while disarmed. Either one recorded by mistake would insert an unexpected frame into the readout stream. It overfills the buffer, so a design that wraps would return late frames in place of the first ones. It reads past the end of the data, so a design whose pointer ran on would return stale memory instead of zeros. It also issues a second readout command, so a design whose pointer did not rewind would return a later word.

// File: rtl/trace_scope_pkg.sv
package trace_scope_pkg;
  localparam int TS_W   = 32;
  localparam int WORD_W = 64;

  typedef enum logic [3:0] {
    OP_WIDTH = 4'd0,
    OP_READ  = 4'd1,
    OP_START = 4'd2,
    OP_DEPTH = 4'd3,
    OP_STOP  = 4'd4,
    OP_COUNT = 4'd5
  } op_e;
endpackage

// File: rtl/trace_arm.sv
// Arming control: start and stop each act after a programmable delay.
module trace_arm #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             armed_o
);
  logic             armed_q, armed_d;
  logic             st_pend_q, st_pend_d, sp_pend_q, sp_pend_d;
  logic [DLY_W-1:0] st_cnt_q, st_cnt_d, sp_cnt_q, sp_cnt_d;

  always_comb begin
    armed_d   = armed_q;
    st_pend_d = st_pend_q;
    st_cnt_d  = st_cnt_q;
    sp_pend_d = sp_pend_q;
    sp_cnt_d  = sp_cnt_q;
    if (st_pend_q) begin
      if (st_cnt_q == '0) begin
        armed_d   = 1'b1;
        st_pend_d = 1'b0;
      end else begin
        st_cnt_d = st_cnt_q - 1'b1;
      end
    end
    if (sp_pend_q) begin
      if (sp_cnt_q == '0) begin
        armed_d   = 1'b0;
        sp_pend_d = 1'b0;
      end else begin
        sp_cnt_d = sp_cnt_q - 1'b1;
      end
    end
    if (start_i) begin
      sp_pend_d = 1'b0;
      if (dly_i == '0) begin
        armed_d   = 1'b1;
        st_pend_d = 1'b0;
      end else begin
        st_pend_d = 1'b1;
        st_cnt_d  = dly_i - 1'b1;
      end
    end
    if (stop_i) begin
      st_pend_d = 1'b0;
      if (dly_i == '0) begin
        armed_d   = 1'b0;
        sp_pend_d = 1'b0;
      end else begin
        sp_pend_d = 1'b1;
        sp_cnt_d  = dly_i - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      st_pend_q <= 1'b0;
      st_cnt_q  <= '0;
      sp_pend_q <= 1'b0;
      sp_cnt_q  <= '0;
    end else begin
      armed_q   <= armed_d;
      st_pend_q <= st_pend_d;
      st_cnt_q  <= st_cnt_d;
      sp_pend_q <= sp_pend_d;
      sp_cnt_q  <= sp_cnt_d;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/trace_store.sv
// Frame buffer: timestamp counter, fill pointer and per-entry registers.
module trace_store
  import trace_scope_pkg::*;
#(
  parameter int PROBE_W = 40,
  parameter int CHAN    = 4,
  parameter int DEPTH   = 8,
  localparam int FRAME_W = TS_W + CHAN + PROBE_W,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               armed_i,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [CHAN-1:0]    hs_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [TS_W-1:0]    ts_q;
  logic [CNT_W-1:0]   count_q, count_d;
  logic               wr_en;
  logic [FRAME_W-1:0] new_frame;
  logic [FRAME_W-1:0] mem_q [DEPTH];

  assign new_frame = {probe_i, hs_i, ts_q};
  assign wr_en     = armed_i && (|hs_i) && (count_q != CNT_W'(DEPTH)) && !clear_i;

  always_comb begin
    count_d = count_q;
    if (clear_i)    count_d = '0;
    else if (wr_en) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q    <= '0;
      count_q <= '0;
    end else begin
      ts_q    <= ts_q + 1'b1;
      count_q <= count_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (count_q == CNT_W'(g))) mem_q[g] <= new_frame;
    end
  end

  assign count_o = count_q;
  assign frame_o = mem_q[rd_idx_i];
endmodule

// File: rtl/trace_read.sv
// Word-serial readout of stored frames, least significant word first.
module trace_read
  import trace_scope_pkg::*;
#(
  parameter int FRAME_W = 76,
  parameter int DEPTH   = 8,
  localparam int WPF    = (FRAME_W + WORD_W - 1) / WORD_W,
  localparam int WSEL_W = (WPF > 1) ? $clog2(WPF) : 1,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  input  logic               pop_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic [WORD_W-1:0]  word_o
);
  logic [CNT_W-1:0]      fr_q, fr_d;
  logic [WSEL_W-1:0]     wd_q, wd_d;
  logic                  have_data;
  logic [WPF*WORD_W-1:0] padded;

  assign have_data = (fr_q < count_i);

  always_comb begin
    padded = '0;
    padded[FRAME_W-1:0] = frame_i;
  end

  always_comb begin
    fr_d = fr_q;
    wd_d = wd_q;
    if (restart_i) begin
      fr_d = '0;
      wd_d = '0;
    end else if (pop_i && have_data) begin
      if (wd_q == WSEL_W'(WPF - 1)) begin
        wd_d = '0;
        fr_d = fr_q + 1'b1;
      end else begin
        wd_d = wd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= '0;
      wd_q <= '0;
    end else begin
      fr_q <= fr_d;
      wd_q <= wd_d;
    end
  end

  assign rd_idx_o = fr_q[IDX_W-1:0];
  assign word_o   = have_data ? padded[int'(wd_q)*WORD_W +: WORD_W] : '0;
endmodule

// File: rtl/trace_scope.sv
// Top: command decode, handshake detect, data-word select.
module trace_scope
  import trace_scope_pkg::*;
#(
  parameter int PROBE_W = 40,
  parameter int CHAN    = 4,
  parameter int DEPTH   = 8,
  parameter int DLY_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [CHAN-1:0]    chan_valid_i,
  input  logic [CHAN-1:0]    chan_ready_i,
  input  logic               cmd_wr_i,
  input  logic [63:0]        cmd_i,
  input  logic               data_rd_i,
  output logic [63:0]        data_o
);
  localparam int FRAME_W = TS_W + CHAN + PROBE_W;
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  op_e                sel_q, sel_d;
  op_e                op;
  logic [DLY_W-1:0]   dly;
  logic               start_cmd, stop_cmd, read_cmd, query_cmd, dly_zero;
  logic               armed, hs_any;
  logic [CHAN-1:0]    hs;
  logic [CNT_W-1:0]   count;
  logic [IDX_W-1:0]   rd_idx;
  logic [FRAME_W-1:0] frame;
  logic [WORD_W-1:0]  word;
  logic               unused_cmd_hi;

  assign op            = op_e'(cmd_i[3:0]);
  assign dly           = cmd_i[DLY_W+3:4];
  assign unused_cmd_hi = ^cmd_i[63:DLY_W+4];
  assign dly_zero      = (dly == '0);
  assign start_cmd     = cmd_wr_i && (op == OP_START);
  assign stop_cmd      = cmd_wr_i && (op == OP_STOP);
  assign read_cmd      = cmd_wr_i && (op == OP_READ);
  assign query_cmd     = cmd_wr_i && (op == OP_WIDTH || op == OP_DEPTH ||
                                      op == OP_COUNT || op == OP_READ);
  assign hs            = chan_valid_i & chan_ready_i;
  assign hs_any        = |hs;

  always_comb begin
    sel_d = sel_q;
    if (query_cmd) sel_d = op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= OP_READ;
    else        sel_q <= sel_d;
  end

  trace_arm #(.DLY_W(DLY_W)) u_arm (
    .clk(clk), .rst_n(rst_n), .start_i(start_cmd), .stop_i(stop_cmd),
    .dly_i(dly), .armed_o(armed)
  );

  trace_store #(.PROBE_W(PROBE_W), .CHAN(CHAN), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clear_i(start_cmd), .armed_i(armed),
    .probe_i(probe_i), .hs_i(hs), .rd_idx_i(rd_idx),
    .count_o(count), .frame_o(frame)
  );

  trace_read #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_read (
    .clk(clk), .rst_n(rst_n), .restart_i(read_cmd || start_cmd),
    .pop_i(data_rd_i && (sel_q == OP_READ)), .count_i(count),
    .frame_i(frame), .rd_idx_o(rd_idx), .word_o(word)
  );

  always_comb begin
    case (sel_q)
      OP_WIDTH: data_o = 64'(FRAME_W);
      OP_DEPTH: data_o = 64'(DEPTH);
      OP_COUNT: data_o = 64'(count);
      OP_READ:  data_o = word;
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/trace_scope_chk.sv
module trace_scope_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic [CNT_W-1:0] count,
  input logic             start_cmd,
  input logic             stop_cmd,
  input logic             dly_zero,
  input logic             hs_any
);
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && !start_cmd) |=> (count == CNT_W'(DEPTH)));

  assert_write_needs_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count) && !$past(start_cmd)) |-> $past(armed && hs_any));

  assert_start_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && dly_zero) |=> armed);

  assert_stop_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && dly_zero) |=> !armed);

  assert_clear_on_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> (count == '0));
endmodule

bind trace_scope trace_scope_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .count(count),
  .start_cmd(start_cmd), .stop_cmd(stop_cmd), .dly_zero(dly_zero),
  .hs_any(hs_any)
);

// File: tb/trace_scope_tb.sv
`timescale 1ns/1ps
module trace_scope_tb;
  localparam int PROBE_W = 40;
  localparam int CHAN    = 4;
  localparam int DEPTH   = 8;
  localparam int FRAME_W = 32 + CHAN + PROBE_W;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [PROBE_W-1:0] probe_i;
  logic [CHAN-1:0]    chan_valid_i, chan_ready_i;
  logic               cmd_wr_i, data_rd_i;
  logic [63:0]        cmd_i, data_o;

  int unsigned  n_cmp = 0, n_bad = 0;
  logic [31:0]  cyc;
  logic [63:0]  exp_q[$];
  logic [63:0]  first_w0;
  int           model_cnt;
  bit           done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0; else cyc <= cyc + 1;

  trace_scope #(.PROBE_W(PROBE_W), .CHAN(CHAN), .DEPTH(DEPTH), .DLY_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .probe_i(probe_i), .chan_valid_i(chan_valid_i),
    .chan_ready_i(chan_ready_i), .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_i),
    .data_rd_i(data_rd_i), .data_o(data_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_cmd(input logic [3:0] op, input logic [15:0] arg);
    cmd_i    = 64'(op) | (64'(arg) << 4);
    cmd_wr_i = 1'b1;
    @(negedge clk);
    cmd_wr_i = 1'b0;
    cmd_i    = '0;
  endtask

  // Driver: one edge of stimulus; pushes expected words when a frame is due.
  task automatic drive(input logic [PROBE_W-1:0] p, input logic [CHAN-1:0] v,
                       input logic [CHAN-1:0] r, input bit expect_frame);
    logic [127:0] fr;
    probe_i = p; chan_valid_i = v; chan_ready_i = r;
    if (expect_frame && model_cnt < DEPTH) begin
      fr = '0;
      fr[FRAME_W-1:0] = {p, v & r, cyc};
      exp_q.push_back(fr[63:0]);
      exp_q.push_back(fr[127:64]);
      if (model_cnt == 0) first_w0 = fr[63:0];
      model_cnt++;
    end
    @(negedge clk);
    probe_i = '0; chan_valid_i = '0; chan_ready_i = '0;
  endtask

  // Monitor side: compare current word with the queue head, then pop.
  task automatic read_word(input string req);
    logic [63:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 64'd0;
    check(req, data_o, e);
    data_rd_i = 1'b1;
    @(negedge clk);
    data_rd_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; probe_i = '0; chan_valid_i = '0; chan_ready_i = '0;
    cmd_wr_i = 1'b0; cmd_i = '0; data_rd_i = 1'b0; model_cnt = 0; first_w0 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 data after reset", data_o, 64'd0);
    host_cmd(4'd5, 0); check("R1/R4 count after reset", data_o, 64'd0);
    host_cmd(4'd0, 0); check("R2 width", data_o, 64'(FRAME_W));
    host_cmd(4'd3, 0); check("R3 depth", data_o, 64'(DEPTH));

    // Disarmed handshake must not be recorded (R5)
    drive(40'hDEAD, 4'b0001, 4'b0001, 0);
    host_cmd(4'd5, 0); check("R5 disarmed ignored", data_o, 64'd0);

    // Start with no delay: next edge records (R6)
    host_cmd(4'd2, 0);
    drive(40'hA1_0000_0001, 4'b0001, 4'b0001, 1);
    drive(40'hA2_0000_0002, 4'b0010, 4'b0000, 0);   // R5 valid without ready
    drive(40'hA3_0000_0003, 4'b0110, 4'b0100, 1);
    // Stop with delay 1: edge 1 still records, edge 2 not (R7)
    host_cmd(4'd4, 1);
    drive(40'hA4_0000_0004, 4'b1000, 4'b1000, 1);
    drive(40'hA5_0000_0005, 4'b1111, 4'b1111, 0);
    host_cmd(4'd5, 0); check("R4/R7 count", data_o, 64'd3);

    // Readout, layout (R8, R9), past-end zeros (R11)
    host_cmd(4'd1, 0);
    for (int i = 0; i < 6; i++) read_word("R8/R9 readout");
    read_word("R11 past end");
    read_word("R11 past end again");
    // Readout restart (R13)
    host_cmd(4'd1, 0);
    check("R13 restart word0", data_o, first_w0);

    // Start with delay 2 clears buffer (R12); edges 1,2 dropped, 3 recorded (R6)
    model_cnt = 0;
    host_cmd(4'd2, 2);
    host_cmd(4'd5, 0); check("R12 cleared on start", data_o, 64'd0);
    drive(40'hB0_0000_0000, 4'b0001, 4'b0011, 0);
    for (int i = 1; i <= 10; i++)
      drive(PROBE_W'(64'hC0_0000_0000 + i), CHAN'(i), 4'b1111, 1);
    host_cmd(4'd4, 0);
    host_cmd(4'd5, 0); check("R10 count saturates", data_o, 64'(DEPTH));
    host_cmd(4'd1, 0);
    for (int i = 0; i < 2*DEPTH; i++) read_word("R10/R6 first frames kept");
    read_word("R11 zero after full buffer");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule